// File: doc/BRIEF.md
# Cell Receive Master for a Byte-Wide Point-to-Point Link

This block is the master side of a byte-wide cell receive link. A slave device raises a cell-available line when it holds a complete cell. The master answers by pulling an active-low read enable. The slave drives one byte, with a start-of-cell flag and a parity bit, in the cycle after each cycle in which it saw the enable low. The master captures those bytes and passes them to a downstream buffer. Each byte goes out with start-of-cell and end-of-cell markers.

The master counts the bytes it has requested, so it knows when a cell ends. The cell length is a static configuration value, forced into the range 16 to 128 bytes. A new cell is only requested when three things hold: the slave has one ready, the downstream buffer reports room for a whole cell, and no pause request is present. If all three still hold at a cell boundary, the enable stays low and the next cell follows with no idle cycle. A pause request from downstream lifts the enable in the next cycle. The transfer then resumes where it stopped, and no byte is lost.

Top module: `cell_rx_master`

## Requirements
- R1: While reset is high, and in the first cycle after it, the read enable `phy_enb_n` is high (no request) and `out_valid` is low.
- R2: Outside a cell, the enable stays high unless `phy_cav`, `buf_room` and not `buf_stall` are all true in the same cycle.
- R3: Every cycle with `phy_enb_n` low yields exactly one output byte. That byte appears with `out_valid` high two cycles later. It carries the slave's data, and `out_par` equals the slave's parity bit. Bytes keep their order.
- R4: `out_sop` is high exactly on the byte the slave flagged as start-of-cell.
- R5: `out_eop` is high on the L-th captured byte of each cell, where L is the effective cell length, and on no other byte.
- R6: A high `buf_stall` sampled at a clock edge makes `phy_enb_n` high in the following cycle. When the stall clears, the request resumes and the cell completes with no byte lost or repeated.
- R7: Each cell uses exactly L enable-low cycles. If `phy_cav` is low at the last request of a cell, the enable is high in the next cycle.
- R8: If `phy_cav` and `buf_room` are high and there is no stall at the last request of a cell, the enable stays low. The first byte of the next cell then leaves in the cycle right after the previous cell's end-of-cell byte.
- R9: The effective length L is `cell_len_cfg` clamped to 16..128. For example, a setting of 5 gives 16 and a setting of 200 gives 128.
- R10: If `buf_room` is low at the last request of a cell, no new cell starts, even with `phy_cav` high, until room returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising-edge active |
| rst | input | 1 | Synchronous reset, active high |
| cell_len_cfg | input | 8 | Cell length in bytes (static; clamped to 16..128) |
| phy_cav | input | 1 | Slave holds a complete cell ready |
| phy_data | input | 8 | Byte driven by the slave |
| phy_soc | input | 1 | Slave start-of-cell flag, with the first byte |
| phy_par | input | 1 | Slave parity bit, forwarded unchecked |
| phy_enb_n | output | 1 | Active-low read enable to the slave |
| buf_room | input | 1 | Downstream buffer can take one whole cell |
| buf_stall | input | 1 | Downstream pause request |
| out_valid | output | 1 | Captured byte valid |
| out_data | output | 8 | Captured byte |
| out_sop | output | 1 | First byte of a cell |
| out_eop | output | 1 | Last byte of a cell |
| out_par | output | 1 | Captured parity bit |

## Verification
Two events can fall in the same cycle. One is the last request of a cell. The other is either the first request of the next cell or a pause or room decision. The bench queues several cells while room is withheld, then releases them with room high, so each boundary has the slave's next cell waiting. It judges the result in three ways: the next start-of-cell byte must appear in the cycle right after the end-of-cell byte, the scoreboard must see every byte in order, and the count of enable-low cycles must equal the number of bytes sent. A second run drops room in the middle of a cell. It checks that the first cell finishes and that no further enable-low cycle appears while the slave still offers a cell.

// File: rtl/cellrx_pkg.sv
package cellrx_pkg;

  // Force a configured length into the supported window.
  function automatic int unsigned clamp_len(int unsigned cfg, int unsigned lo, int unsigned hi);
    if (cfg < lo) return lo;
    if (cfg > hi) return hi;
    return cfg;
  endfunction

  // Index of the final byte of a cell of n bytes (bytes numbered from zero).
  function automatic int unsigned last_index(int unsigned n);
    return n - 1;
  endfunction

endpackage

// File: rtl/cellrx_req_ctl.sv
module cellrx_req_ctl #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] len_eff,
  input  logic             cav,
  input  logic             room,
  input  logic             stall,
  output logic             enb_n,
  output logic             fire,
  output logic             cell_start
);

  logic [CNT_W-1:0] req_cnt;
  logic [CNT_W-1:0] cnt_after;
  logic             at_bound;
  logic             mid_cell;
  logic             go;

  // A request is made in every cycle the enable is low.
  always_comb begin
    fire       = !enb_n;
    cnt_after  = req_cnt + CNT_W'(fire);
    at_bound   = (cnt_after == len_eff);
    mid_cell   = (cnt_after != '0) && !at_bound;
    go         = mid_cell ? !stall : (cav && room && !stall);
    cell_start = !mid_cell && go;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      enb_n   <= 1'b1;
      req_cnt <= '0;
    end else begin
      enb_n   <= !go;
      req_cnt <= at_bound ? '0 : cnt_after;
    end
  end

  assert_idle_gate_R2: assert property (@(posedge clk) disable iff (rst)
    (req_cnt == '0 && enb_n && !(cav && room)) |=> enb_n);

  assert_stall_pause_R6: assert property (@(posedge clk) disable iff (rst)
    stall |=> enb_n);

  assert_cnt_bound_R7: assert property (@(posedge clk) disable iff (rst)
    req_cnt < len_eff);

  assert_bound_room_R10: assert property (@(posedge clk) disable iff (rst)
    (fire && (req_cnt + 1'b1 == len_eff) && !room) |=> enb_n);

endmodule

// File: rtl/cellrx_capture.sv
module cellrx_capture
  import cellrx_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CNT_W-1:0]  len_eff,
  input  logic              fire,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_soc,
  input  logic              in_par,
  output logic              o_valid,
  output logic [DATA_W-1:0] o_data,
  output logic              o_sop,
  output logic              o_eop,
  output logic              o_par
);

  logic             pend_q;
  logic [CNT_W-1:0] rcv_cnt;
  logic [CNT_W-1:0] last_idx;
  logic             is_last;

  assign last_idx = CNT_W'(last_index(32'(len_eff)));
  assign is_last  = (rcv_cnt == last_idx);

  // pend_q marks the cycle in which the slave drives the requested byte.
  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q  <= 1'b0;
      o_valid <= 1'b0;
      o_data  <= '0;
      o_sop   <= 1'b0;
      o_eop   <= 1'b0;
      o_par   <= 1'b0;
      rcv_cnt <= '0;
    end else begin
      pend_q  <= fire;
      o_valid <= pend_q;
      if (pend_q) begin
        o_data  <= in_data;
        o_sop   <= in_soc;
        o_par   <= in_par;
        o_eop   <= is_last;
        rcv_cnt <= is_last ? '0 : rcv_cnt + 1'b1;
      end else begin
        o_sop <= 1'b0;
        o_eop <= 1'b0;
      end
    end
  end

  assert_eop_qual_R5: assert property (@(posedge clk) disable iff (rst)
    o_eop |-> o_valid);

  assert_rcv_bound_R5: assert property (@(posedge clk) disable iff (rst)
    rcv_cnt < len_eff);

endmodule

// File: rtl/cell_rx_master.sv
module cell_rx_master
  import cellrx_pkg::*;
#(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned CFG_W   = 8,
  parameter int unsigned LEN_MIN = 16,
  parameter int unsigned LEN_MAX = 128
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CFG_W-1:0]  cell_len_cfg,
  input  logic              phy_cav,
  input  logic [DATA_W-1:0] phy_data,
  input  logic              phy_soc,
  input  logic              phy_par,
  output logic              phy_enb_n,
  input  logic              buf_room,
  input  logic              buf_stall,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              out_sop,
  output logic              out_eop,
  output logic              out_par
);

  localparam int unsigned CNT_W = $clog2(LEN_MAX + 1);

  logic [CNT_W-1:0] len_eff;
  logic             req_fire;
  logic             cell_start;

  assign len_eff = CNT_W'(clamp_len(32'(cell_len_cfg), LEN_MIN, LEN_MAX));

  cellrx_req_ctl #(.CNT_W(CNT_W)) req_i (
    .clk        (clk),
    .rst        (rst),
    .len_eff    (len_eff),
    .cav        (phy_cav),
    .room       (buf_room),
    .stall      (buf_stall),
    .enb_n      (phy_enb_n),
    .fire       (req_fire),
    .cell_start (cell_start)
  );

  cellrx_capture #(.DATA_W(DATA_W), .CNT_W(CNT_W)) cap_i (
    .clk     (clk),
    .rst     (rst),
    .len_eff (len_eff),
    .fire    (req_fire),
    .in_data (phy_data),
    .in_soc  (phy_soc),
    .in_par  (phy_par),
    .o_valid (out_valid),
    .o_data  (out_data),
    .o_sop   (out_sop),
    .o_eop   (out_eop),
    .o_par   (out_par)
  );

  always_comb begin
    if (rst == 1'b0) begin
      assert_len_clamped_R9: assert (len_eff >= LEN_MIN && len_eff <= LEN_MAX)
        else $error("effective cell length outside window");
    end
  end

  assert_req_to_byte_R3: assert property (@(posedge clk) disable iff (rst)
    !phy_enb_n |-> ##2 out_valid);

  assert_start_gated_R2: assert property (@(posedge clk) disable iff (rst)
    cell_start |-> (buf_room && !buf_stall));

endmodule

// File: tb/cell_rx_master_tb_top.sv
`timescale 1ns/1ps
module cell_rx_master_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] cfg = 8'd53;
  logic       cav = 1'b0;
  logic [7:0] pdata = 8'd0;
  logic       psoc = 1'b0;
  logic       ppar = 1'b0;
  logic       room = 1'b0;
  logic       stall = 1'b0;
  logic       enb_n;
  logic       ov;
  logic [7:0] od;
  logic       osop;
  logic       oeop;
  logic       opar;

  always #4 clk = ~clk;

  cell_rx_master dut_i (
    .clk(clk), .rst(rst), .cell_len_cfg(cfg), .phy_cav(cav), .phy_data(pdata),
    .phy_soc(psoc), .phy_par(ppar), .phy_enb_n(enb_n), .buf_room(room),
    .buf_stall(stall), .out_valid(ov), .out_data(od), .out_sop(osop),
    .out_eop(oeop), .out_par(opar)
  );

  int     checks = 0;
  int     fails = 0;
  bit [8:0] slave_q[$];
  bit [9:0] exp_q[$];
  int     not_started = 0;
  int     low_cnt = 0;
  int     tot_bytes = 0;
  longint cyc = 0;
  bit     b2b_chk = 1'b0;
  longint last_eop_cyc = -100;
  bit [7:0] seed_byte = 8'h3c;

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int eff_len(int c);
    if (c < 16) return 16;
    if (c > 128) return 128;
    return c;
  endfunction

  task automatic push_cell(int n);
    for (int i = 0; i < n; i++) begin
      slave_q.push_back({(i == 0), seed_byte});
      exp_q.push_back({(i == n - 1), (i == 0), seed_byte});
      seed_byte = seed_byte + 8'd29;
    end
    not_started++;
    tot_bytes += n;
  endtask

  task automatic drain();
    int t;
    t = 0;
    while ((exp_q.size() != 0 || slave_q.size() != 0) && t < 5000) begin
      @(negedge clk);
      t++;
    end
    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R3", "drain left bytes", exp_q.size(), 0);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  // cycle counter
  initial forever begin
    @(posedge clk);
    cyc++;
  end

  // slave model: drives a byte after each edge at which it saw the enable low
  initial begin
    bit       en_s;
    bit [8:0] b;
    forever begin
      @(negedge clk);
      en_s = enb_n;
      @(posedge clk);
      if (!rst) begin
        if (!en_s) begin
          if (slave_q.size() == 0) begin
            check(1'b0, "R7", "request with no byte queued", 0, 1);
          end else begin
            b = slave_q.pop_front();
            pdata <= b[7:0];
            psoc  <= b[8];
            ppar  <= ^b[7:0];
            if (b[8]) not_started--;
          end
        end else begin
          pdata <= 8'd0;
          psoc  <= 1'b0;
          ppar  <= 1'b0;
        end
        cav <= (not_started > 0);
      end
    end
  end

  // scoreboard monitor
  initial begin
    bit [9:0] e;
    forever begin
      @(negedge clk);
      if (!rst) begin
        if (!enb_n) low_cnt++;
        if (ov) begin
          if (exp_q.size() == 0) begin
            check(1'b0, "R3", "unexpected byte", od, -1);
          end else begin
            e = exp_q.pop_front();
            check(od == e[7:0], "R3", "data", od, e[7:0]);
            check(opar == ^e[7:0], "R3", "parity", opar, ^e[7:0]);
            check(osop == e[8], "R4", "sop", osop, e[8]);
            check(oeop == e[9], "R5", "eop", oeop, e[9]);
            if (osop && b2b_chk && last_eop_cyc > 0)
              check(cyc == last_eop_cyc + 1, "R8", "gap after eop", int'(cyc - last_eop_cyc), 1);
            if (oeop) last_eop_cyc = cyc;
          end
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL R3 watchdog actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    bit ok;
    int t;
    // R1: reset state
    repeat (5) @(negedge clk);
    check(enb_n == 1'b1, "R1", "enable in reset", enb_n, 1);
    check(ov == 1'b0, "R1", "valid in reset", ov, 0);
    rst = 1'b0;
    @(negedge clk);
    check(enb_n == 1'b1, "R1", "enable after reset", enb_n, 1);
    check(ov == 1'b0, "R1", "valid after reset", ov, 0);

    // R2: no cell offered -> no request; cell offered but no room -> no request
    room = 1'b1;
    ok = 1'b1;
    repeat (10) begin @(negedge clk); if (!enb_n) ok = 1'b0; end
    check(ok, "R2", "request without cell", ok, 1);
    room = 1'b0;
    push_cell(eff_len(cfg));
    ok = 1'b1;
    repeat (20) begin @(negedge clk); if (!enb_n) ok = 1'b0; end
    check(ok, "R2", "request without room", ok, 1);
    room = 1'b1;
    drain();
    check(low_cnt == tot_bytes, "R7", "enable-low cycles single cell", low_cnt, tot_bytes);

    // R8: back-to-back cells
    room = 1'b0;
    push_cell(eff_len(cfg));
    push_cell(eff_len(cfg));
    push_cell(eff_len(cfg));
    repeat (3) @(negedge clk);
    b2b_chk = 1'b1;
    last_eop_cyc = -100;
    room = 1'b1;
    drain();
    b2b_chk = 1'b0;
    check(low_cnt == tot_bytes, "R7", "enable-low cycles back-to-back", low_cnt, tot_bytes);

    // R6: stall pulses during transfers
    push_cell(eff_len(cfg));
    push_cell(eff_len(cfg));
    t = 0;
    while (!ov && t < 200) begin @(negedge clk); t++; end
    for (int k = 0; k < 6; k++) begin
      repeat (5 + 3 * k) @(negedge clk);
      stall = 1'b1;
      @(negedge clk);
      check(enb_n == 1'b1, "R6", "enable during stall", enb_n, 1);
      repeat (k % 3) @(negedge clk);
      stall = 1'b0;
    end
    drain();
    check(low_cnt == tot_bytes, "R6", "no byte lost across stalls", low_cnt, tot_bytes);

    // R10: room withdrawn in the middle of a cell
    push_cell(eff_len(cfg));
    push_cell(eff_len(cfg));
    t = 0;
    while (!(ov && osop) && t < 200) begin @(negedge clk); t++; end
    room = 1'b0;
    t = 0;
    while (exp_q.size() > eff_len(cfg) && t < 500) begin @(negedge clk); t++; end
    ok = 1'b1;
    repeat (30) begin @(negedge clk); if (!enb_n) ok = 1'b0; end
    check(ok, "R10", "request with cell but no room", ok, 1);
    check(exp_q.size() == eff_len(cfg), "R10", "second cell held", exp_q.size(), eff_len(cfg));
    room = 1'b1;
    drain();
    check(low_cnt == tot_bytes, "R7", "enable-low cycles after room return", low_cnt, tot_bytes);

    // R9: length clamping at both ends and exact minimum
    cfg = 8'd5;
    push_cell(eff_len(cfg));
    push_cell(eff_len(cfg));
    drain();
    cfg = 8'd200;
    push_cell(eff_len(cfg));
    push_cell(eff_len(cfg));
    drain();
    cfg = 8'd16;
    push_cell(eff_len(cfg));
    drain();
    check(low_cnt == tot_bytes, "R9", "enable-low cycles with clamped lengths", low_cnt, tot_bytes);

    summary();
    $finish;
  end

endmodule